// File: doc/BRIEF.md
# Packet buffer allocation MMU

This block hands out packet numbers from a pool of uniform packet buffers inside an Ethernet controller and keeps the queues of numbers that move between software and the MAC. Software drives a 3-bit command code together with a packet-number operand. Each accepted command keeps `busy` high for a fixed number of cycles and takes effect on the clock edge at which `busy` falls. The command codes are 1 for allocating a transmit buffer, 2 for resetting the whole pool, 3 for dropping the oldest receive entry, 4 for dropping and releasing it, 5 for releasing a named buffer, 6 for queueing a named buffer for transmit, and 7 for emptying the two transmit-side FIFOs. Code 0 does nothing.

An allocation that finds no free buffer does not return an error. It stays pending and completes by itself as soon as a buffer comes free, and it raises the allocation interrupt when it does. The MAC side uses three valid/ready streams. The receive stream takes a fresh buffer from the pool and appends its number to the receive FIFO. The transmit stream offers the head of the transmit queue. The completion stream accepts numbers of finished transmissions into the completion FIFO. A transfer on any stream happens in a cycle where valid and ready are both high. The block lowers ready whenever it cannot take the item, and the MAC must hold valid and its data until the transfer happens.

Top module: `pbuf_mmu`

## Requirements
- R1: After reset, `busy`=0, `alloc_result`=0x80, `alloc_irq`=0, `enq_err`=0, `rx_empty`=1, `txc_empty`=1, `txq_valid`=0, `rx_ready`=1, `txdone_ready`=1, and every buffer is free.
- R2: A command presented while `busy` is low is accepted. `busy` is then high for exactly BUSY_CYC (4) cycles, and the command's effect is visible in the first cycle in which `busy` is low again. A command presented while `busy` is high is dropped.
- R3: Code 1 takes the lowest-numbered free buffer and sets `alloc_result` = {2'b00, number}. If no buffer is free, it sets `alloc_result` to 0x80 (bit 7 = failed) and leaves an allocation pending.
- R4: A pending allocation takes the lowest free buffer in the first cycle after one comes free that is not a command's effect cycle. It then writes `alloc_result` = {2'b00, number} and sets `alloc_irq`. While an allocation is pending, `rx_ready` stays low.
- R5: `alloc_irq` is set by every allocation that succeeds and stays set until `irq_ack`. When a set and an acknowledge fall in the same cycle, the set wins.
- R6: `rx_ready` is high when a buffer is free, the receive FIFO is not full, no allocation is pending and no command takes effect in that cycle. A transfer takes the lowest free buffer and appends it to the receive FIFO. `rx_head` shows the oldest entry whenever `rx_empty` is low.
- R7: Code 3 removes the oldest receive entry and leaves its buffer allocated. Code 4 removes it and frees the buffer. Either code has no effect when the receive FIFO is empty.
- R8: Code 5 frees the buffer given by `cmd_pnr`, and freeing a buffer that is already free changes nothing. If the completion FIFO's head equals `cmd_pnr`, that head is removed as well.
- R9: Code 6 appends `cmd_pnr` to the transmit queue. The MAC sees the queue in order on `txq_valid`/`txq_pkt` and removes the head on `txq_ready`. Queueing into a full queue leaves the queue as it was and sets `enq_err`, which stays set until code 2.
- R10: `txdone_ready` is high when the completion FIFO is not full and no transmit-side clear takes effect in that cycle. Accepted numbers appear in order on `txc_head` while `txc_empty` is low.
- R11: Code 7 empties the transmit queue and the completion FIFO. Buffers, the receive FIFO and `enq_err` are left as they are.
- R12: Code 2 returns the block to the state of R1. This frees all buffers, empties all FIFOs and cancels a pending allocation.
- R13: Code 0 occupies the sequencer like any other command and changes no other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, accepted when busy is low |
| cmd_code | input | 3 | Command code (0..7) |
| cmd_pnr | input | PW (6) | Packet-number operand for codes 5 and 6 |
| busy | output | 1 | Command in progress |
| alloc_result | output | PW+2 (8) | Bit 7 failed, bit 6 zero, low bits allocated number |
| alloc_irq | output | 1 | Allocation-complete interrupt, sticky |
| irq_ack | input | 1 | Clears alloc_irq |
| enq_err | output | 1 | Sticky transmit-queue overflow flag |
| rx_valid | input | 1 | MAC requests a receive buffer |
| rx_ready | output | 1 | Receive buffer grant |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_head | output | PW (6) | Oldest receive packet number |
| txq_valid | output | 1 | Transmit queue has an entry |
| txq_ready | input | 1 | MAC takes the transmit head |
| txq_pkt | output | PW (6) | Transmit queue head |
| txdone_valid | input | 1 | MAC reports a finished transmission |
| txdone_ready | output | 1 | Completion FIFO accepts |
| txdone_pkt | input | PW (6) | Number of the finished packet |
| txc_empty | output | 1 | Completion FIFO empty |
| txc_head | output | PW (6) | Completion FIFO head |

## Verification
The bench drives the pool to exhaustion and frees one buffer to reach a pending allocation. A design that completed it in the effect cycle, or let the receive stream take that buffer first, would report the wrong number or never raise the interrupt. It frees one buffer twice and then allocates twice. A design that toggled the free state instead of clearing it would lose the buffer and fail the first allocation. It fills the transmit queue, the receive FIFO and the completion FIFO. An off-by-one full flag would show up as a silently lost entry or a missing error flag. A long random phase overlaps stream transfers, acknowledges, dropped commands and clears with command effects, and compares against the reference model every cycle. This exposes wrong priorities between the command, the pending allocation and the receive grant.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ALLOC = 3'd1,
    CMD_RESET = 3'd2,
    CMD_RXPOP = 3'd3,
    CMD_RXREL = 3'd4,
    CMD_FREE  = 3'd5,
    CMD_ENQ   = 3'd6,
    CMD_TXRST = 3'd7
  } mmu_cmd_e;
endpackage

// File: rtl/pb_fifo.sv
module pb_fifo #(
  parameter int W     = 6,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign dout  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else if (clr) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end

  // R9
  push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full && !clr));
  // R7
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty && !clr));
endmodule

// File: rtl/pb_freemap.sv
module pb_freemap #(
  parameter int N  = 64,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          alloc_en,
  input  logic          free_en,
  input  logic [IW-1:0] free_idx,
  output logic          any_free,
  output logic [IW-1:0] low_idx
);
  logic [N-1:0] used_q;

  always_comb begin
    low_idx  = '0;
    any_free = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!used_q[i]) begin
        low_idx  = IW'(i);
        any_free = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used_q <= '0;
    else if (clr) used_q <= '0;
    else begin
      if (free_en)  used_q[free_idx] <= 1'b0;
      if (alloc_en) used_q[low_idx]  <= 1'b1;
    end
  end

  // R3
  alloc_needs_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> any_free);
endmodule

// File: rtl/pb_cmd_seq.sv
module pb_cmd_seq #(
  parameter int BUSY_CYC = 4,
  parameter int PW       = 6,
  localparam int CW      = $clog2(BUSY_CYC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_code,
  input  logic [PW-1:0]      cmd_pnr,
  output logic               busy,
  output logic               commit,
  output mmu_pkg::mmu_cmd_e  code_q,
  output logic [PW-1:0]      pnr_q
);
  logic [CW-1:0] cnt;

  assign busy   = (cnt != '0);
  assign commit = (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      code_q <= mmu_pkg::CMD_NOP;
      pnr_q  <= '0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else if (cmd_valid) begin
      cnt    <= CW'(BUSY_CYC);
      code_q <= mmu_pkg::mmu_cmd_e'(cmd_code);
      pnr_q  <= cmd_pnr;
    end
  end

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy);
  // R2
  commit_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);
endmodule

// File: rtl/pbuf_mmu.sv
module pbuf_mmu #(
  parameter int NUM_PKT    = 64,
  parameter int FIFO_DEPTH = 16,
  parameter int BUSY_CYC   = 4,
  localparam int PW        = $clog2(NUM_PKT),
  localparam int RW        = PW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_code,
  input  logic [PW-1:0] cmd_pnr,
  output logic          busy,
  output logic [RW-1:0] alloc_result,
  output logic          alloc_irq,
  input  logic          irq_ack,
  output logic          enq_err,
  input  logic          rx_valid,
  output logic          rx_ready,
  output logic          rx_empty,
  output logic [PW-1:0] rx_head,
  output logic          txq_valid,
  input  logic          txq_ready,
  output logic [PW-1:0] txq_pkt,
  input  logic          txdone_valid,
  output logic          txdone_ready,
  input  logic [PW-1:0] txdone_pkt,
  output logic          txc_empty,
  output logic [PW-1:0] txc_head
);
  import mmu_pkg::*;

  localparam logic [RW-1:0] ARR_IDLE = {1'b1, {(RW-1){1'b0}}};

  logic          commit;
  mmu_cmd_e      code_q;
  logic [PW-1:0] pnr_q;
  logic          any_free;
  logic [PW-1:0] low_idx;
  logic          pending_q, irq_q, err_q;
  logic [RW-1:0] arr_q;
  logic          rx_full, txq_full, txq_empty, txc_full;

  pb_cmd_seq #(.BUSY_CYC(BUSY_CYC), .PW(PW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_pnr(cmd_pnr), .busy(busy), .commit(commit), .code_q(code_q), .pnr_q(pnr_q));

  logic all_clr, tx_clr, do_alloc, pend_grant, alloc_ok, rx_fire;
  logic free_en, rx_pop, txq_push, txc_pop;
  logic [PW-1:0] free_idx;

  assign all_clr    = commit && (code_q == CMD_RESET);
  assign tx_clr     = commit && (code_q == CMD_RESET || code_q == CMD_TXRST);
  assign do_alloc   = commit && (code_q == CMD_ALLOC);
  assign pend_grant = !commit && pending_q && any_free;
  assign alloc_ok   = (do_alloc && any_free) || pend_grant;
  assign rx_ready   = !commit && !pending_q && any_free && !rx_full;
  assign rx_fire    = rx_valid && rx_ready;
  assign rx_pop     = commit && (code_q == CMD_RXPOP || code_q == CMD_RXREL) && !rx_empty;
  assign free_en    = commit && ((code_q == CMD_RXREL && !rx_empty) || code_q == CMD_FREE);
  assign free_idx   = (code_q == CMD_RXREL) ? rx_head : pnr_q;
  assign txq_push   = commit && (code_q == CMD_ENQ) && !txq_full;
  assign txq_valid  = !txq_empty;
  assign txdone_ready = !txc_full && !tx_clr;
  assign txc_pop    = commit && (code_q == CMD_FREE) && !txc_empty && (txc_head == pnr_q);

  pb_freemap #(.N(NUM_PKT)) u_map (
    .clk(clk), .rst_n(rst_n), .clr(all_clr), .alloc_en(alloc_ok || rx_fire),
    .free_en(free_en), .free_idx(free_idx), .any_free(any_free), .low_idx(low_idx));

  pb_fifo #(.W(PW), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n), .clr(all_clr), .push(rx_fire), .din(low_idx),
    .pop(rx_pop), .dout(rx_head), .empty(rx_empty), .full(rx_full));

  pb_fifo #(.W(PW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(txq_push), .din(pnr_q),
    .pop(txq_valid && txq_ready), .dout(txq_pkt), .empty(txq_empty), .full(txq_full));

  pb_fifo #(.W(PW), .DEPTH(FIFO_DEPTH)) u_txc (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(txdone_valid && txdone_ready),
    .din(txdone_pkt), .pop(txc_pop), .dout(txc_head), .empty(txc_empty), .full(txc_full));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      irq_q     <= 1'b0;
      err_q     <= 1'b0;
      arr_q     <= ARR_IDLE;
    end else if (all_clr) begin
      pending_q <= 1'b0;
      irq_q     <= 1'b0;
      err_q     <= 1'b0;
      arr_q     <= ARR_IDLE;
    end else begin
      if (do_alloc) begin
        if (any_free) arr_q <= {2'b00, low_idx};
        else begin
          arr_q     <= ARR_IDLE;
          pending_q <= 1'b1;
        end
      end else if (pend_grant) begin
        arr_q     <= {2'b00, low_idx};
        pending_q <= 1'b0;
      end
      if (alloc_ok) irq_q <= 1'b1;
      else if (irq_ack) irq_q <= 1'b0;
      if (commit && code_q == CMD_ENQ && txq_full) err_q <= 1'b1;
    end
  end

  assign alloc_result = arr_q;
  assign alloc_irq    = irq_q;
  assign enq_err      = err_q;

  // R5
  irq_rise_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alloc_irq) |-> !alloc_result[RW-1]);
  // R6
  rx_push_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> !rx_empty);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_err && !all_clr) |=> enq_err);
  // R10
  txdone_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txdone_valid && txdone_ready) |=> !txc_empty);
endmodule

// File: tb/test_pbuf_mmu.sv
`timescale 1ns/1ps
module test_pbuf_mmu;
  localparam int NUM_PKT = 64;
  localparam int DEPTH   = 16;
  localparam int BUSY    = 4;
  localparam int PW      = 6;
  localparam int IDLE    = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_code = '0;
  logic [PW-1:0] cmd_pnr = '0;
  logic irq_ack = 1'b0, rx_valid = 1'b0, txq_ready = 1'b0, txdone_valid = 1'b0;
  logic [PW-1:0] txdone_pkt = '0;
  logic busy, alloc_irq, enq_err, rx_ready, rx_empty, txq_valid, txdone_ready, txc_empty;
  logic [7:0] alloc_result;
  logic [PW-1:0] rx_head, txq_pkt, txc_head;

  always #2.5 clk = ~clk;

  pbuf_mmu #(.NUM_PKT(NUM_PKT), .FIFO_DEPTH(DEPTH), .BUSY_CYC(BUSY)) i_pbuf_mmu (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_pnr(cmd_pnr),
    .busy(busy), .alloc_result(alloc_result), .alloc_irq(alloc_irq), .irq_ack(irq_ack),
    .enq_err(enq_err), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_empty(rx_empty),
    .rx_head(rx_head), .txq_valid(txq_valid), .txq_ready(txq_ready), .txq_pkt(txq_pkt),
    .txdone_valid(txdone_valid), .txdone_ready(txdone_ready), .txdone_pkt(txdone_pkt),
    .txc_empty(txc_empty), .txc_head(txc_head));

  int n_chk = 0, n_fail = 0;
  bit run_cmp = 0, done = 0;

  task automatic check(input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d at %0t", what, act, exp, $time);
    end
  endtask

  // reference model
  bit m_used [NUM_PKT];
  int rxq[$], txq[$], txc[$];
  int m_cnt, m_code, m_pnr, m_arr;
  bit m_pend, m_irq, m_err;

  function automatic int mlow();
    for (int i = 0; i < NUM_PKT; i++) if (!m_used[i]) return i;
    return -1;
  endfunction
  function automatic bit exp_rx_ready();
    return (m_cnt != 1) && !m_pend && (mlow() >= 0) && (rxq.size() < DEPTH);
  endfunction
  function automatic bit exp_txc_ready();
    return (txc.size() < DEPTH) && !(m_cnt == 1 && (m_code == 2 || m_code == 7));
  endfunction
  task automatic mclear();
    foreach (m_used[i]) m_used[i] = 0;
    rxq.delete(); txq.delete(); txc.delete();
    m_arr = IDLE; m_pend = 0; m_irq = 0; m_err = 0;
  endtask

  always @(posedge clk) begin
    bit cm, rxr, tcr, seti;
    int lo, ntx, ntc, nrx, pc;
    if (!rst_n) begin
      mclear(); m_cnt = 0; m_code = 0; m_pnr = 0;
    end else begin
      pc = m_cnt; cm = (pc == 1); lo = mlow();
      ntx = txq.size(); ntc = txc.size(); nrx = rxq.size();
      rxr = exp_rx_ready(); tcr = exp_txc_ready(); seti = 0;
      if (txq_ready && ntx > 0) void'(txq.pop_front());
      if (cm) begin
        case (m_code)
          1: if (lo >= 0) begin m_used[lo] = 1; m_arr = lo; seti = 1; end
             else begin m_arr = IDLE; m_pend = 1; end
          3: if (nrx > 0) void'(rxq.pop_front());
          4: if (nrx > 0) begin m_used[rxq[0]] = 0; void'(rxq.pop_front()); end
          5: begin
               m_used[m_pnr] = 0;
               if (ntc > 0 && txc[0] == m_pnr) void'(txc.pop_front());
             end
          6: if (ntx >= DEPTH) m_err = 1; else txq.push_back(m_pnr);
          default: ;
        endcase
      end
      if (!cm && m_pend && lo >= 0) begin
        m_used[lo] = 1; m_arr = lo; m_pend = 0; seti = 1;
      end
      if (rx_valid && rxr) begin m_used[lo] = 1; rxq.push_back(lo); end
      if (txdone_valid && tcr) txc.push_back(int'(txdone_pkt));
      if (seti) m_irq = 1; else if (irq_ack) m_irq = 0;
      if (cm && m_code == 7) begin txq.delete(); txc.delete(); end
      if (cm && m_code == 2) mclear();
      if (cm) m_cnt = 0;
      else if (pc != 0) m_cnt = pc - 1;
      else if (cmd_valid) begin
        m_cnt = BUSY; m_code = int'(cmd_code); m_pnr = int'(cmd_pnr);
      end
    end
  end

  always @(negedge clk) begin
    if (run_cmp) begin
      check(busy, m_cnt != 0, "R2 busy");
      check(alloc_result, m_arr, "R3 alloc_result");
      check(alloc_irq, m_irq, "R5 alloc_irq");
      check(enq_err, m_err, "R9 enq_err");
      check(rx_ready, exp_rx_ready(), "R6 rx_ready");
      check(rx_empty, rxq.size() == 0, "R6 rx_empty");
      if (rxq.size() > 0) check(rx_head, rxq[0], "R6 rx_head");
      check(txq_valid, txq.size() > 0, "R9 txq_valid");
      if (txq.size() > 0) check(txq_pkt, txq[0], "R9 txq_pkt");
      check(txdone_ready, exp_txc_ready(), "R10 txdone_ready");
      check(txc_empty, txc.size() == 0, "R10 txc_empty");
      if (txc.size() > 0) check(txc_head, txc[0], "R10 txc_head");
    end
  end

  task automatic do_cmd(input int code, input int pnr);
    int n = 0;
    cmd_valid = 1'b1; cmd_code = code[2:0]; cmd_pnr = pnr[PW-1:0];
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) begin n++; @(negedge clk); end
    check(n, BUSY, "R2 busy length");
  endtask

  task automatic pulse(ref logic sig, input int cycles);
    sig = 1'b1;
    repeat (cycles) @(negedge clk);
    sig = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_cmp = 1;
    // R1 reset state
    check(busy, 0, "R1 busy"); check(alloc_result, 8'h80, "R1 alloc_result");
    check(alloc_irq, 0, "R1 irq"); check(enq_err, 0, "R1 err");
    check(rx_empty, 1, "R1 rx_empty"); check(txc_empty, 1, "R1 txc_empty");
    check(txq_valid, 0, "R1 txq_valid"); check(rx_ready, 1, "R1 rx_ready");
    check(txdone_ready, 1, "R1 txdone_ready");
    // R3 first allocation, R5 interrupt and ack
    do_cmd(1, 0);
    check(alloc_result, 0, "R3 first alloc");
    check(alloc_irq, 1, "R5 irq set");
    pulse(irq_ack, 1);
    check(alloc_irq, 0, "R5 irq ack");
    for (int i = 1; i < NUM_PKT; i++) do_cmd(1, 0);
    check(alloc_result, 63, "R3 last buffer");
    do_cmd(1, 0);
    check(alloc_result, 8'h80, "R3 alloc fails when exhausted");
    check(rx_ready, 0, "R4 rx held while pending");
    pulse(irq_ack, 1);
    // R4 deferred completion
    do_cmd(5, 5);
    check(alloc_result, 8'h80, "R4 not yet in effect cycle");
    @(negedge clk);
    check(alloc_result, 5, "R4 deferred alloc");
    check(alloc_irq, 1, "R4 irq on deferred alloc");
    // R8 double release ignored
    do_cmd(5, 7); do_cmd(5, 7);
    do_cmd(1, 0);
    check(alloc_result, 7, "R8 released buffer reused");
    do_cmd(1, 0);
    check(alloc_result, 8'h80, "R8 double release gave no extra buffer");
    // R12 full reset
    do_cmd(2, 0);
    check(alloc_result, 8'h80, "R12 result"); check(alloc_irq, 0, "R12 irq");
    check(rx_ready, 1, "R12 pending cancelled");
    // R6/R7 receive path
    pulse(rx_valid, 3);
    check(rx_head, 0, "R6 rx head");
    do_cmd(3, 0);
    check(rx_head, 1, "R7 pop keeps order");
    do_cmd(4, 0);
    check(rx_head, 2, "R7 pop-release");
    do_cmd(1, 0);
    check(alloc_result, 1, "R7 released rx buffer reusable");
    do_cmd(4, 0);
    check(rx_empty, 1, "R7 rx empty");
    do_cmd(3, 0);
    check(rx_empty, 1, "R7 pop on empty no effect");
    do_cmd(1, 0);
    check(alloc_result, 2, "R7 buffer 2 freed");
    pulse(rx_valid, 20);
    check(rx_ready, 0, "R6 rx fifo full");
    check(rx_head, 3, "R6 rx head after fill");
    do_cmd(2, 0);
    // R9 transmit queue
    do_cmd(6, 10); do_cmd(6, 11); do_cmd(6, 12);
    check(txq_pkt, 10, "R9 tx head");
    pulse(txq_ready, 1);
    check(txq_pkt, 11, "R9 tx pop");
    for (int i = 0; i < 14; i++) do_cmd(6, 20 + i);
    check(enq_err, 0, "R9 no error at full");
    do_cmd(6, 40);
    check(enq_err, 1, "R9 overflow flag");
    check(txq_pkt, 11, "R9 queue unchanged");
    // R10 completion FIFO, R8 head removal
    txdone_pkt = 3; txdone_valid = 1'b1; @(negedge clk);
    txdone_pkt = 4; @(negedge clk); txdone_valid = 1'b0;
    check(txc_head, 3, "R10 completion head");
    do_cmd(5, 3);
    check(txc_head, 4, "R8 completion head removed");
    do_cmd(5, 9);
    check(txc_head, 4, "R8 non-matching head kept");
    pulse(rx_valid, 1);
    // R11 transmit reset
    do_cmd(7, 0);
    check(txq_valid, 0, "R11 tx queue empty"); check(txc_empty, 1, "R11 completion empty");
    check(rx_empty, 0, "R11 rx kept"); check(enq_err, 1, "R11 err kept");
    // R13 no-op
    do_cmd(0, 0);
    check(rx_empty, 0, "R13 rx kept"); check(enq_err, 1, "R13 err kept");
    do_cmd(2, 0);
    check(enq_err, 0, "R12 err cleared"); check(rx_empty, 1, "R12 rx cleared");
    // random phase against the model
    for (int c = 0; c < 4000; c++) begin
      int code;
      code = $urandom % 8;
      if (code == 2 && ($urandom % 6) != 0) code = 1;
      cmd_valid    = ($urandom % 3) == 0;
      cmd_code     = code[2:0];
      cmd_pnr      = PW'($urandom);
      rx_valid     = ($urandom % 3) == 0;
      txq_ready    = ($urandom % 3) == 0;
      txdone_valid = ($urandom % 3) == 0;
      txdone_pkt   = PW'($urandom);
      irq_ack      = ($urandom % 8) == 0;
      @(negedge clk);
    end
    cmd_valid = 0; rx_valid = 0; txq_ready = 0; txdone_valid = 0; irq_ack = 0;
    repeat (8) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog expired act=1 exp=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule